// File: doc/BRIEF.md
# Single-Cycle 32-bit Load-Store Core

This block is a small processor core that completes one instruction per clock. It fetches a 32-bit instruction word from an internal instruction memory, decodes it, reads up to two operands from a 32 x 32-bit register file, computes in an ALU, and in the same cycle writes the register file or an internal data word memory and updates the program counter. It covers ten operations: register add, subtract, OR and signed set-less-than, add-immediate, word load, word store, branch on equal, branch on not-equal and an absolute jump.

The instruction memory is filled through a write port while reset is held. After reset is released the core runs on its own. A debug port reads any register with no delay, so a program's results can be inspected. Two outputs report faults. One marks a load or store whose effective address is not a multiple of four. The other goes high and stays high once an unsupported instruction is reached, and from then on the core is frozen.

Top module: `cpu_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0, every register to 0 and the illegal flag to 0. Execution begins at instruction word 0 on the first rising edge after reset is released.
- R2: An instruction with opcode 0 (bits 31:26) and shamt (bits 10:6) equal to 0 writes rd (bits 15:11) with rs (bits 25:21) plus rt (bits 20:16) when funct (bits 5:0) is 32. It writes rs minus rt when funct is 34, and rs OR rt when funct is 37.
- R3: Opcode 0 with funct 42 writes 1 to rd when rs is less than rt compared as signed two's-complement values, and writes 0 otherwise.
- R4: Opcode 8 sign-extends the 16-bit immediate (bits 15:0), adds it to rs and writes the sum to rt.
- R5: Register 0 always reads as zero, and any write aimed at it is discarded.
- R6: Opcode 35 loads a word and opcode 43 stores one. The effective address is rs plus the sign-extended immediate. The memory is byte addressed, so word n sits at address 4n. A load writes rt, and a store writes the value of rt.
- R7: A load or store whose effective address has bits 1:0 not equal to 0 drives misalign_o high for that cycle. The store is dropped or the register write is suppressed, and the program counter still advances by 4.
- R8: Opcode 4 branches when rs equals rt and opcode 5 branches when they differ. A taken branch sets the program counter to PC+4 plus four times the sign-extended immediate. Otherwise the counter moves to PC+4.
- R9: Opcode 2 sets the program counter to the upper 4 bits of PC+4, followed by the 26-bit target field, followed by two zero bits.
- R10: Any other opcode, and any opcode-0 word whose funct is not 32, 34, 37 or 42 or whose shamt is not 0, writes nothing. It raises illegal_o from the next cycle, and the flag and the frozen program counter hold until reset.
- R11: The debug port returns the register selected by dbg_idx combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Write strobe for the instruction memory |
| prog_addr | input | IAW (6) | Word index written in instruction memory |
| prog_data | input | 32 | Instruction word to store |
| dbg_idx | input | 5 | Register selected for debug read |
| dbg_data | output | 32 | Value of the selected register |
| illegal_o | output | 1 | Sticky flag: unsupported instruction reached, core frozen |
| misalign_o | output | 1 | Current load or store has an unaligned address |

## Verification
The bench builds the core with its default sizes: 64 instruction words and 64 data words. With 64 instruction words, a straight-line random program of two dozen instructions fits, along with the directed loops and forward jumps. Random stores use offsets from register 0 that cover all 64 data words, up to byte address 252, so the top and bottom of the data memory are both reached. The 6-bit word index also makes an unaligned offset alias onto a word that the bench can read back, which shows whether a store was dropped.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RIW   = 5;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_JMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_BNE  = 6'd5;
    localparam logic [5:0] OPC_ADDI = 6'd8;
    localparam logic [5:0] OPC_LW   = 6'd35;
    localparam logic [5:0] OPC_SW   = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic            legal;
        logic            reg_we;
        logic [RIW-1:0]  wr_idx;
        logic            use_imm;
        alu_op_e         alu_op;
        logic            mem_rd;
        logic            mem_wr;
        logic            br_eq;
        logic            br_ne;
        logic            jump;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter  int NREGS  = 32,
    parameter  int XLEN   = 32,
    parameter  int NRD    = 3,
    localparam int IW     = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   ra   [NRD],
    output logic [XLEN-1:0] rdat [NRD],
    input  logic            we,
    input  logic [IW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdat[p] = (ra[p] == '0) ? '0 : regs_q[ra[p]];
    end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);

    logic [5:0] opc, fn;
    logic [4:0] rt, rd, shamt;

    assign opc   = instr[31:26];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign shamt = instr[10:6];
    assign fn    = instr[5:0];

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opc)
            OPC_REG: begin
                ctrl.wr_idx = rd;
                ctrl.legal  = (shamt == '0);
                unique case (fn)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.legal  = 1'b0;
                endcase
                ctrl.reg_we = ctrl.legal;
            end
            OPC_ADDI: begin
                ctrl.legal   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.wr_idx  = rt;
                ctrl.use_imm = 1'b1;
            end
            OPC_LW: begin
                ctrl.legal   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.wr_idx  = rt;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                ctrl.legal   = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.legal  = 1'b1;
                ctrl.alu_op = ALU_SUB;
                ctrl.br_eq  = 1'b1;
            end
            OPC_BNE: begin
                ctrl.legal  = 1'b1;
                ctrl.alu_op = ALU_SUB;
                ctrl.br_ne  = 1'b1;
            end
            OPC_JMP: begin
                ctrl.legal = 1'b1;
                ctrl.jump  = 1'b1;
            end
            default: ctrl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic [IAW-1:0]  prog_addr,
    input  logic [31:0]     prog_data,
    input  logic [RIW-1:0]  dbg_idx,
    output logic [XLEN-1:0] dbg_data,
    output logic            illegal_o,
    output logic            misalign_o
);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic            illegal_q;
    logic [31:0]     imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    logic [31:0]     instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] imm_ext, alu_b, alu_y, wb_data, load_data;
    logic            alu_zero, stall, misalign, take_br, dmem_we, rf_we;
    logic [RIW-1:0]  ra   [3];
    logic [XLEN-1:0] rdat [3];

    // instruction store, filled from outside
    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    assign instr = imem[pc_q[IAW+1:2]];

    cpu_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    assign ra[0] = instr[25:21];
    assign ra[1] = instr[20:16];
    assign ra[2] = dbg_idx;

    cpu_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NRD(3)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra   (ra),
        .rdat (rdat),
        .we   (rf_we),
        .wa   (ctrl.wr_idx),
        .wd   (wb_data)
    );

    assign imm_ext = sext16(instr[15:0]);
    assign alu_b   = ctrl.use_imm ? imm_ext : rdat[1];

    cpu_alu u_alu (
        .a    (rdat[0]),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // fault handling
    assign stall    = illegal_q || !ctrl.legal;
    assign misalign = (ctrl.mem_rd || ctrl.mem_wr) && (alu_y[1:0] != 2'b00);

    // data memory, word indexed by the byte address
    assign dmem_we   = ctrl.mem_wr && !misalign && !stall;
    assign load_data = dmem[alu_y[DAW+1:2]];

    always_ff @(posedge clk) begin
        if (dmem_we) dmem[alu_y[DAW+1:2]] <= rdat[1];
    end

    assign wb_data = ctrl.mem_rd ? load_data : alu_y;
    assign rf_we   = ctrl.reg_we && !stall && !(ctrl.mem_rd && misalign);

    // next program counter
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
    assign take_br    = (ctrl.br_eq && alu_zero) || (ctrl.br_ne && !alu_zero);

    always_comb begin
        if (stall)          pc_next = pc_q;
        else if (ctrl.jump) pc_next = jmp_target;
        else if (take_br)   pc_next = br_target;
        else                pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            pc_q <= pc_next;
            if (!ctrl.legal) illegal_q <= 1'b1;
        end
    end

    assign dbg_data   = rdat[2];
    assign illegal_o  = illegal_q;
    assign misalign_o = misalign;

endmodule

// File: rtl/cpu_core_checker.sv
module cpu_core_checker (
    input logic        clk,
    input logic        rst,
    input logic        illegal_o,
    input logic        misalign_o,
    input logic [31:0] pc_q,
    input logic [4:0]  dbg_idx,
    input logic [31:0] dbg_data,
    input logic        dmem_we,
    input logic        rf_we
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == 32'd0 && !illegal_o)); // R1

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
        (dbg_idx == 5'd0) |-> (dbg_data == 32'd0)); // R5

    AST_MISALIGN_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> !dmem_we); // R7

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00); // R8

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> illegal_o); // R10

    AST_ILLEGAL_PC_HELD: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> $stable(pc_q)); // R10

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!rf_we && !dmem_we)); // R10

endmodule

bind cpu_core cpu_core_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .illegal_o  (illegal_o),
    .misalign_o (misalign_o),
    .pc_q       (pc_q),
    .dbg_idx    (dbg_idx),
    .dbg_data   (dbg_data),
    .dmem_we    (dmem_we),
    .rf_we      (rf_we)
);

// File: tb/cpu_core_bench.sv
`timescale 1ns/1ps
module cpu_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_data;
    logic        illegal_o, misalign_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] prog [64];
    int          plen;

    always #4 clk = ~clk;

    cpu_core u_cpu_core (
        .clk        (clk),
        .rst        (rst),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .dbg_idx    (dbg_idx),
        .dbg_data   (dbg_data),
        .illegal_o  (illegal_o),
        .misalign_o (misalign_o)
    );

    // ---------------- encoders ----------------
    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(input int widx);
        return {6'd2, widx[25:0]};
    endfunction

    function automatic logic [31:0] sx(input int imm);
        return {{16{imm[15]}}, imm[15:0]};
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // loads the program with reset held; reset stays high afterwards
    task automatic load_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < plen; i++) begin
            prog_we   = 1'b1;
            prog_addr = 6'(i);
            prog_data = prog[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_run(input int cyc);
        rst = 1'b0;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic step(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    task automatic rd_reg(input int r, output logic [31:0] v);
        dbg_idx = 5'(r);
        #1;
        v = dbg_data;
    endtask

    task automatic chk_reg(input string tag, input int r, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(r, v);
        check($sformatf("%s r%0d", tag, r), v, exp);
    endtask

    // ---------------- random program model ----------------
    logic [31:0] mreg [32];
    logic [31:0] mmem [64];
    bit          mwr  [64];

    task automatic random_round();
        int nwr;
        plen = 0;
        nwr  = 0;
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < 64; i++) mwr[i] = 0;
        for (int k = 0; k < 24; k++) begin
            int kind, rd, rs, rt, imm, w;
            logic [31:0] res;
            kind = int'($urandom_range(0, 6));
            rd   = int'($urandom_range(0, 31));
            rs   = int'($urandom_range(0, 31));
            rt   = int'($urandom_range(0, 31));
            imm  = int'($urandom & 32'hffff);
            if (kind == 6 && nwr == 0) kind = 4;
            case (kind)
                0: begin res = mreg[rs] + mreg[rt]; add(enc_r(6'd32, rd, rs, rt)); end
                1: begin res = mreg[rs] - mreg[rt]; add(enc_r(6'd34, rd, rs, rt)); end
                2: begin res = mreg[rs] | mreg[rt]; add(enc_r(6'd37, rd, rs, rt)); end
                3: begin res = ($signed(mreg[rs]) < $signed(mreg[rt])) ? 32'd1 : 32'd0;
                         add(enc_r(6'd42, rd, rs, rt)); end
                4: begin res = mreg[rs] + sx(imm); add(enc_i(6'd8, rd, rs, imm)); end
                5: begin
                    w = int'($urandom_range(0, 63));
                    add(enc_i(6'd43, rt, 0, w * 4));
                    mmem[w] = mreg[rt];
                    if (!mwr[w]) nwr++;
                    mwr[w] = 1;
                    res = 32'd0;
                    rd  = 0;
                end
                default: begin
                    do w = int'($urandom_range(0, 63)); while (!mwr[w]);
                    add(enc_i(6'd35, rd, 0, w * 4));
                    res = mmem[w];
                end
            endcase
            if (rd != 0) mreg[rd] = res;
        end
        add(enc_j(plen));
        load_prog();
        release_run(30);
        for (int r = 0; r < 32; r++) chk_reg("R2 R3 R4 R5 R6 random", r, mreg[r]);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));

        // arithmetic program
        plen = 0;
        add(enc_i(6'd8, 1, 0, -5));
        add(enc_i(6'd8, 2, 0, 7));
        add(enc_r(6'd32, 3, 1, 2));
        add(enc_r(6'd34, 4, 1, 2));
        add(enc_r(6'd37, 5, 1, 2));
        add(enc_r(6'd42, 6, 1, 2));
        add(enc_r(6'd42, 7, 2, 1));
        add(enc_i(6'd8, 0, 0, 5));
        add(enc_r(6'd32, 0, 1, 2));
        add(enc_i(6'd8, 8, 0, 16'h7fff));
        add(enc_j(10));
        load_prog();
        for (int r = 0; r < 32; r++) chk_reg("R1 reset clears", r, 32'd0);
        check("R1 illegal after reset", {31'd0, illegal_o}, 32'd0);
        release_run(16);
        chk_reg("R4 addi negative", 1, 32'hFFFF_FFFB);
        chk_reg("R4 addi positive", 8, 32'h0000_7FFF);
        chk_reg("R2 add", 3, 32'd2);
        chk_reg("R2 sub", 4, 32'hFFFF_FFF4);
        chk_reg("R2 or", 5, 32'hFFFF_FFFF);
        chk_reg("R3 slt signed true", 6, 32'd1);
        chk_reg("R3 slt signed false", 7, 32'd0);
        chk_reg("R5 write to r0 dropped", 0, 32'd0);
        rd_reg(3, v);
        dbg_idx = 5'd4;
        #1;
        check("R11 debug read without clock", dbg_data, 32'hFFFF_FFF4);

        // load/store program
        plen = 0;
        add(enc_i(6'd8, 1, 0, 16));
        add(enc_i(6'd8, 2, 0, 16'h1234));
        add(enc_i(6'd43, 2, 1, 4));
        add(enc_i(6'd43, 1, 1, -4));
        add(enc_i(6'd35, 3, 1, 4));
        add(enc_i(6'd35, 4, 1, -4));
        add(enc_i(6'd8, 9, 0, 20));
        add(enc_i(6'd35, 5, 9, 0));
        add(enc_i(6'd35, 6, 0, 12));
        add(enc_j(9));
        load_prog();
        chk_reg("R1 regs cleared between programs", 3, 32'd0);
        release_run(14);
        chk_reg("R6 load after store pos offset", 3, 32'h1234);
        chk_reg("R6 load after store neg offset", 4, 32'd16);
        chk_reg("R6 same word via other base", 5, 32'h1234);
        chk_reg("R6 byte address 12 is word 3", 6, 32'd16);

        // misaligned accesses
        plen = 0;
        add(enc_i(6'd8, 1, 0, 8));
        add(enc_i(6'd8, 2, 0, 77));
        add(enc_i(6'd8, 4, 0, 99));
        add(enc_i(6'd43, 2, 1, 0));
        add(enc_i(6'd8, 3, 0, 55));
        add(enc_i(6'd43, 3, 1, 2));
        add(enc_i(6'd35, 4, 1, 1));
        add(enc_i(6'd35, 5, 1, 0));
        add(enc_i(6'd8, 6, 0, 1));
        add(enc_j(9));
        load_prog();
        release_run(4);
        check("R7 aligned op no flag", {31'd0, misalign_o}, 32'd0);
        step(1);
        check("R7 misaligned store flagged", {31'd0, misalign_o}, 32'd1);
        step(1);
        check("R7 misaligned load flagged", {31'd0, misalign_o}, 32'd1);
        step(10);
        chk_reg("R7 misaligned load no write", 4, 32'd99);
        chk_reg("R7 misaligned store dropped", 5, 32'd77);
        chk_reg("R7 pc advanced past fault", 6, 32'd1);

        // branches and jumps
        plen = 0;
        add(enc_i(6'd8, 1, 0, 3));
        add(enc_i(6'd8, 2, 0, 3));
        add(enc_i(6'd4, 2, 1, 1));
        add(enc_i(6'd8, 10, 0, 1));
        add(enc_i(6'd5, 2, 1, 1));
        add(enc_i(6'd8, 11, 0, 1));
        add(enc_i(6'd8, 1, 1, -1));
        add(enc_i(6'd8, 12, 12, 1));
        add(enc_i(6'd5, 0, 1, -3));
        add(enc_j(11));
        add(enc_i(6'd8, 13, 0, 1));
        add(enc_i(6'd8, 14, 0, 5));
        add(enc_j(12));
        load_prog();
        release_run(40);
        chk_reg("R8 beq taken skips", 10, 32'd0);
        chk_reg("R8 bne not taken falls through", 11, 32'd1);
        chk_reg("R8 backward bne loop count", 12, 32'd3);
        chk_reg("R8 loop counter", 1, 32'd0);
        chk_reg("R9 jump skips", 13, 32'd0);
        chk_reg("R9 jump target reached", 14, 32'd5);

        // illegal opcode
        plen = 0;
        add(enc_i(6'd8, 1, 0, 1));
        add(32'hFC00_0000);
        add(enc_i(6'd8, 2, 0, 1));
        add(enc_j(3));
        load_prog();
        release_run(1);
        check("R10 flag low before illegal executes", {31'd0, illegal_o}, 32'd0);
        step(1);
        check("R10 flag raised", {31'd0, illegal_o}, 32'd1);
        step(10);
        check("R10 flag sticky", {31'd0, illegal_o}, 32'd1);
        chk_reg("R10 frozen, next instr not run", 2, 32'd0);
        chk_reg("R10 earlier instr done", 1, 32'd1);

        // illegal funct
        plen = 0;
        add(enc_r(6'd0, 5, 0, 0) | 32'h0000_0000);
        add(enc_i(6'd8, 6, 0, 1));
        add(enc_j(2));
        prog[0] = {6'd0, 5'd0, 5'd0, 5'd5, 5'd0, 6'd0};
        load_prog();
        check("R1 reset clears illegal", {31'd0, illegal_o}, 32'd0);
        release_run(6);
        check("R10 bad funct flagged", {31'd0, illegal_o}, 32'd1);
        chk_reg("R10 bad funct no write", 6, 32'd0);

        // random programs
        for (int n = 0; n < 20; n++) random_round();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule